// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller. It serves up to six banks of up to 32 pins each through a simple word-addressed register bus. Software uses it to drive pins high or low, to choose per pin whether the pad drives or listens, and to read back the synchronised pad levels. It can also be set to catch rising or falling transitions on any pin. A caught transition is held in a sticky status bit, and the masked status of every bank is combined into one interrupt request.

The pads are sampled by a two-flop synchroniser. Transitions are found by comparing the newest synchronised sample with the one before it. Banks 0 to 2 sit in a low address window and banks 3 and up sit in a second window starting at byte 0x100. Both windows use the same per-register offsets. A per-pin parameter mask reverses the meaning of the direction bit on selected pins. The total pin count must lie between 32 and 192, and the last bank carries whatever pins remain.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset no pin drives (padOutEn all 0), padOut is all 0, both edge enables and all edge status bits are 0, and irq is 0. The edge mask reads all ones over the valid pins. The direction register reads back the inversion mask.
- R2: Bank b's registers sit at byte address W(b) plus the register offset. W(b) is b×4 for b below 3 and 0x100 + (b−3)×4 otherwise. The offsets are: level 0x00, direction 0x0C, output set 0x18, output clear 0x24, rising enable 0x30, falling enable 0x3C, edge status 0x48, edge mask 0x9C.
- R3: Writing the set register drives padOut high for every pin whose data bit is 1, and writing the clear register drives it low for every such pin. A 0 bit leaves the pin's latch unchanged. Both addresses read back the output latch, and the change is visible on padOut after the write's clock edge.
- R4: padOutEn for a pin equals its direction bit XOR the pin's bit in the DIR_INVERT parameter, so 1 in the direction register means output on normal pins and input on inverted pins.
- R5: The level register returns the pads through a two-flop synchroniser. A pad change made before clock edge n is not visible to a read sampled at edge n+1, and is visible to a read sampled at edge n+2 or later.
- R6: With its rising enable set, a pin's 0-to-1 transition sets its edge status bit. With only the rising enable set, a 1-to-0 transition does not set it.
- R7: With its falling enable set, a 1-to-0 transition sets the status bit, and a 0-to-1 transition with only the falling enable set does not. With both enables set, either transition sets it.
- R8: An edge status bit stays set until a 1 is written to that bit of the status register. Writing 0 to the bit leaves it set.
- R9: When a status clear write and a new enabled edge hit the same bit on the same clock edge, the bit stays set.
- R10: irq is the OR over all pins of (edge status AND edge mask). It follows status and mask combinationally, so a pad transition made before edge n raises irq after edge n+2.
- R11: Bits above the last valid pin of the last bank read as 0 in every register and ignore writes.
- R12: A read returns data on busRdata after the clock edge that samples it. Unmapped addresses read 0, and writes to the level register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access request for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| padIn | input | NUM_PINS | Asynchronous pad input levels |
| padOut | output | NUM_PINS | Output latch per pin |
| padOutEn | output | NUM_PINS | Output driver enable per pin |
| irq | output | 1 | Combined masked edge interrupt |

## Verification
Every result has a fixed latency, and each check samples on the falling clock edge that follows the rising edge where the result is due. Set, clear, direction and mask writes show up on padOut, padOutEn and irq one rising edge after the write. Read data appears one edge after the read is sampled. A pad change reaches the level register two edges later and the sticky status and irq three edges later. The level and interrupt tests sample once just before and once just after that edge. The collision test places the status clear on exactly the edge where the new transition latches.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BANK_W    = 3;
  localparam int BANK_PINS = 32;
  localparam int HIGH_WIN  = 'h100;
  localparam int NUM_KINDS = 8;

  typedef enum logic [3:0] {
    RK_LEVEL = 4'd0,
    RK_DIR   = 4'd1,
    RK_SET   = 4'd2,
    RK_CLR   = 4'd3,
    RK_RISE  = 4'd4,
    RK_FALL  = 4'd5,
    RK_STAT  = 4'd6,
    RK_MASK  = 4'd7,
    RK_NONE  = 4'd15
  } regKind_e;

  // Strobes passed from address decode to the register datapath.
  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic [BANK_W-1:0] bank;
    regKind_e          kind;
  } busStrobe_t;

  function automatic int regOffset(input regKind_e k);
    case (k)
      RK_LEVEL: return 'h00;
      RK_DIR:   return 'h0C;
      RK_SET:   return 'h18;
      RK_CLR:   return 'h24;
      RK_RISE:  return 'h30;
      RK_FALL:  return 'h3C;
      RK_STAT:  return 'h48;
      RK_MASK:  return 'h9C;
      default:  return -1;
    endcase
  endfunction

  // Low window holds banks 0..2, high window holds the rest.
  function automatic int bankBase(input int b);
    return (b < 3) ? b * 4 : HIGH_WIN + (b - 3) * 4;
  endfunction

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 6,
  parameter int ADDR_W    = 9
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);

  regKind_e          kindHit;
  logic [BANK_W-1:0] bankHit;

  // One comparator per (bank, register) pair; at most one matches.
  always_comb begin
    kindHit = RK_NONE;
    bankHit = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int k = 0; k < NUM_KINDS; k++) begin
        if (busAddr == ADDR_W'(bankBase(b) + regOffset(regKind_e'(k)))) begin
          kindHit = regKind_e'(k);
          bankHit = BANK_W'(b);
        end
      end
    end
  end

  always_comb begin
    strobe.kind = kindHit;
    strobe.bank = bankHit;
    strobe.wrEn = busSel && busWrite && (kindHit != RK_NONE) && (kindHit != RK_LEVEL);
    strobe.rdEn = busSel && !busWrite;
  end

endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
  import gpio_bank_pkg::*;
#(
  parameter int               WIDTH    = 32,
  parameter int               BANK_IDX = 0,
  parameter logic [WIDTH-1:0] INVERT   = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       strobe,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] levelQ,
  output logic [WIDTH-1:0] dirQ,
  output logic [WIDTH-1:0] outQ,
  output logic [WIDTH-1:0] riseQ,
  output logic [WIDTH-1:0] fallQ,
  output logic [WIDTH-1:0] statQ,
  output logic [WIDTH-1:0] maskQ,
  output logic             irqBank
);

  logic             selBank;
  logic             wrDir, wrSet, wrClr, wrRise, wrFall, wrStat, wrMask;
  logic [WIDTH-1:0] syncQ, prevQ;
  logic [WIDTH-1:0] edgeHit, statNext, outNext;

  assign selBank = strobe.wrEn && (strobe.bank == BANK_W'(BANK_IDX));
  assign wrDir   = selBank && (strobe.kind == RK_DIR);
  assign wrSet   = selBank && (strobe.kind == RK_SET);
  assign wrClr   = selBank && (strobe.kind == RK_CLR);
  assign wrRise  = selBank && (strobe.kind == RK_RISE);
  assign wrFall  = selBank && (strobe.kind == RK_FALL);
  assign wrStat  = selBank && (strobe.kind == RK_STAT);
  assign wrMask  = selBank && (strobe.kind == RK_MASK);

  // Edge found between the newest synchronised sample and the previous one.
  assign edgeHit = (levelQ & ~prevQ & riseQ) | (~levelQ & prevQ & fallQ);

  // A fresh edge overrides a same-cycle write-one-to-clear.
  always_comb begin
    statNext = statQ;
    if (wrStat) statNext = statNext & ~wdata;
    statNext = statNext | edgeHit;
  end

  always_comb begin
    outNext = outQ;
    if (wrSet) outNext = outNext | wdata;
    if (wrClr) outNext = outNext & ~wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '0;
      levelQ <= '0;
      prevQ  <= '0;
      dirQ   <= INVERT;
      outQ   <= '0;
      riseQ  <= '0;
      fallQ  <= '0;
      statQ  <= '0;
      maskQ  <= '1;
    end else begin
      syncQ  <= padIn;
      levelQ <= syncQ;
      prevQ  <= levelQ;
      outQ   <= outNext;
      statQ  <= statNext;
      if (wrDir)  dirQ  <= wdata;
      if (wrRise) riseQ <= wdata;
      if (wrFall) fallQ <= wdata;
      if (wrMask) maskQ <= wdata;
    end
  end

  assign irqBank = |(statQ & maskQ);

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int                  NUM_PINS   = 180,
  parameter logic [NUM_PINS-1:0] DIR_INVERT = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStrobe_t          strobe,
  input  logic [31:0]         busWdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [31:0]         busRdata,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOutEn,
  output logic                irq
);

  localparam int NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS;
  localparam int LAST_W    = NUM_PINS - (NUM_BANKS - 1) * BANK_PINS;

  logic [31:0]          levelV [NUM_BANKS];
  logic [31:0]          dirV   [NUM_BANKS];
  logic [31:0]          outV   [NUM_BANKS];
  logic [31:0]          riseV  [NUM_BANKS];
  logic [31:0]          fallV  [NUM_BANKS];
  logic [31:0]          statV  [NUM_BANKS];
  logic [31:0]          maskV  [NUM_BANKS];
  logic [NUM_BANKS-1:0] irqV;
  logic [31:0]          rdNext;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int W  = (b == NUM_BANKS - 1) ? LAST_W : BANK_PINS;
    localparam int LO = b * BANK_PINS;
    localparam logic [W-1:0] INV = DIR_INVERT[LO +: W];

    logic [W-1:0] levelQ, dirQ, outQ, riseQ, fallQ, statQ, maskQ;

    gpio_bank_slice #(
      .WIDTH   (W),
      .BANK_IDX(b),
      .INVERT  (INV)
    ) u_slice (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe),
      .wdata  (busWdata[W-1:0]),
      .padIn  (padIn[LO +: W]),
      .levelQ (levelQ),
      .dirQ   (dirQ),
      .outQ   (outQ),
      .riseQ  (riseQ),
      .fallQ  (fallQ),
      .statQ  (statQ),
      .maskQ  (maskQ),
      .irqBank(irqV[b])
    );

    assign levelV[b] = 32'(levelQ);
    assign dirV[b]   = 32'(dirQ);
    assign outV[b]   = 32'(outQ);
    assign riseV[b]  = 32'(riseQ);
    assign fallV[b]  = 32'(fallQ);
    assign statV[b]  = 32'(statQ);
    assign maskV[b]  = 32'(maskQ);

    assign padOut[LO +: W]   = outQ;
    assign padOutEn[LO +: W] = dirQ ^ INV;
  end

  always_comb begin
    rdNext = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobe.bank == BANK_W'(b)) begin
        case (strobe.kind)
          RK_LEVEL:       rdNext = levelV[b];
          RK_DIR:         rdNext = dirV[b];
          RK_SET, RK_CLR: rdNext = outV[b];
          RK_RISE:        rdNext = riseV[b];
          RK_FALL:        rdNext = fallV[b];
          RK_STAT:        rdNext = statV[b];
          RK_MASK:        rdNext = maskV[b];
          default:        rdNext = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             busRdata <= '0;
    else if (strobe.rdEn)  busRdata <= rdNext;
  end

  assign irq = |irqV;

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int                  NUM_PINS   = 180,
  parameter int                  ADDR_W     = 9,
  parameter logic [NUM_PINS-1:0] DIR_INVERT = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOutEn,
  output logic                irq
);

  localparam int NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS;

  busStrobe_t strobe;

  gpio_bank_decode #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W)
  ) u_decode (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  gpio_bank_datapath #(
    .NUM_PINS  (NUM_PINS),
    .DIR_INVERT(DIR_INVERT)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busWdata(busWdata),
    .padIn   (padIn),
    .busRdata(busRdata),
    .padOut  (padOut),
    .padOutEn(padOutEn),
    .irq     (irq)
  );

endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
  parameter int                  NUM_PINS   = 180,
  parameter int                  ADDR_W     = 9,
  parameter logic [NUM_PINS-1:0] DIR_INVERT = '0
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWrite,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [31:0]         busWdata,
  input logic [31:0]         busRdata,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOutEn,
  input logic                irq
);

  localparam logic [ADDR_W-1:0] A_DIR0  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_SET0  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_CLR0  = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] A_HOLE  = ADDR_W'('hF0);

  // R1: first active cycle after reset shows a quiet block
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOut == '0 && padOutEn == '0 && !irq));

  // R3: set write on bank 0 ORs the data into the output latch
  p_set_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == A_SET0) |=>
      (padOut[31:0] == ($past(padOut[31:0]) | $past(busWdata))));

  // R3: clear write on bank 0 removes the data bits from the output latch
  p_clr_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == A_CLR0) |=>
      (padOut[31:0] == ($past(padOut[31:0]) & ~$past(busWdata))));

  // R4: direction write on bank 0 sets the driver enables through the inversion mask
  p_dir_sense_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == A_DIR0) |=>
      (padOutEn[31:0] == ($past(busWdata) ^ DIR_INVERT[31:0])));

  // R12: a read of an unmapped address returns zero next cycle
  p_hole_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && busAddr == A_HOLE) |=> (busRdata == '0));

endmodule

bind gpio_bank_ctrl gpio_bank_checker #(
  .NUM_PINS  (NUM_PINS),
  .ADDR_W    (ADDR_W),
  .DIR_INVERT(DIR_INVERT)
) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .padOut  (padOut),
  .padOutEn(padOutEn),
  .irq     (irq)
);

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;

  localparam int NP = 180;
  localparam int AW = 9;
  localparam logic [NP-1:0] INV = 180'd15 << 86;

  localparam int O_LVL  = 'h00;
  localparam int O_DIR  = 'h0C;
  localparam int O_SET  = 'h18;
  localparam int O_CLR  = 'h24;
  localparam int O_RISE = 'h30;
  localparam int O_FALL = 'h3C;
  localparam int O_STAT = 'h48;
  localparam int O_MASK = 'h9C;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut;
  logic [NP-1:0] padOutEn;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW), .DIR_INVERT(INV)) u_gpio_bank_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .padOut(padOut),
    .padOutEn(padOutEn), .irq(irq)
  );

  function automatic logic [AW-1:0] regAddr(input int bank, input int off);
    return AW'((bank < 3) ? bank * 4 + off : 'h100 + (bank - 3) * 4 + off);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tidyBank(input int bank);
    busWr(regAddr(bank, O_RISE), 32'h0);
    busWr(regAddr(bank, O_FALL), 32'h0);
    busWr(regAddr(bank, O_STAT), 32'hFFFF_FFFF);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 padOut", padOut[31:0] | padOut[179:160], 32'h0);
    check("R1 padOutEn", (|padOutEn) ? 32'h1 : 32'h0, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    busRd(regAddr(0, O_MASK), d); check("R1 mask bank0", d, 32'hFFFF_FFFF);
    busRd(regAddr(5, O_MASK), d); check("R1 mask bank5", d, 32'h000F_FFFF);
    busRd(regAddr(2, O_DIR), d);  check("R1 dir bank2", d, 32'h03C0_0000);
    busRd(regAddr(1, O_STAT), d); check("R1 stat bank1", d, 32'h0);
    busRd(regAddr(3, O_RISE), d); check("R1 rise bank3", d, 32'h0);
  endtask

  task automatic testMap();
    logic [31:0] d;
    busWr(regAddr(3, O_RISE), 32'h1234_5678);
    busWr(regAddr(4, O_FALL), 32'h0BAD_F00D);
    busRd(12'h130, d); check("R2 bank3 rise at 0x130", d, 32'h1234_5678);
    busRd(12'h140, d); check("R2 bank4 fall at 0x140", d, 32'h0BAD_F00D);
    busRd(regAddr(0, O_RISE), d); check("R2 bank0 rise untouched", d, 32'h0);
    busRd(regAddr(1, O_FALL), d); check("R2 bank1 fall untouched", d, 32'h0);
    tidyBank(3); tidyBank(4);
  endtask

  task automatic testSetClr();
    logic [31:0] d;
    busWr(regAddr(1, O_SET), 32'h0000_00FF);
    check("R3 set", padOut[63:32], 32'h0000_00FF);
    busWr(regAddr(1, O_CLR), 32'h0000_000F);
    check("R3 clear", padOut[63:32], 32'h0000_00F0);
    busWr(regAddr(1, O_SET), 32'h0);
    check("R3 zero set no change", padOut[63:32], 32'h0000_00F0);
    busRd(regAddr(1, O_SET), d); check("R3 read set", d, 32'h0000_00F0);
    busRd(regAddr(1, O_CLR), d); check("R3 read clr", d, 32'h0000_00F0);
    busWr(regAddr(1, O_CLR), 32'hFFFF_FFFF);
    check("R3 clear all", padOut[63:32], 32'h0);
  endtask

  task automatic testDir();
    logic [31:0] d;
    busWr(regAddr(0, O_DIR), 32'h0000_00F0);
    check("R4 bank0 enables", padOutEn[31:0], 32'h0000_00F0);
    busWr(regAddr(2, O_DIR), 32'h0);
    check("R4 inverted pins drive", padOutEn[95:64], 32'h03C0_0000);
    busWr(regAddr(2, O_DIR), 32'h03C0_0001);
    check("R4 mixed sense", padOutEn[95:64], 32'h0000_0001);
    busRd(regAddr(2, O_DIR), d); check("R4 dir readback", d, 32'h03C0_0001);
    busWr(regAddr(0, O_DIR), 32'h0);
    busWr(regAddr(2, O_DIR), 32'h03C0_0000);
    check("R4 all inputs again", (|padOutEn) ? 32'h1 : 32'h0, 32'h0);
  endtask

  task automatic testLevel();
    logic [31:0] d;
    @(negedge clk); padIn[40] = 1'b1;
    busRd(regAddr(1, O_LVL), d); check("R5 not yet visible", d, 32'h0);
    busRd(regAddr(1, O_LVL), d); check("R5 visible", d, 32'h0000_0100);
    @(negedge clk); padIn[40] = 1'b0;
    idle(4);
    busRd(regAddr(1, O_LVL), d); check("R5 low again", d, 32'h0);
  endtask

  task automatic testRise();
    logic [31:0] d;
    busWr(regAddr(0, O_RISE), 32'h0000_0008);
    @(negedge clk); padIn[3] = 1'b1;
    idle(2); check("R10 irq before latch", {31'b0, irq}, 32'h0);
    idle(1); check("R10 irq after latch", {31'b0, irq}, 32'h1);
    busRd(regAddr(0, O_STAT), d); check("R6 rising latched", d, 32'h0000_0008);
    busWr(regAddr(0, O_STAT), 32'h0000_0008);
    @(negedge clk); padIn[3] = 1'b0;
    idle(4);
    busRd(regAddr(0, O_STAT), d); check("R6 falling ignored", d, 32'h0);
    check("R6 irq quiet", {31'b0, irq}, 32'h0);
    tidyBank(0);
  endtask

  task automatic testFallBoth();
    logic [31:0] d;
    busWr(regAddr(0, O_FALL), 32'h0000_0020);
    @(negedge clk); padIn[5] = 1'b1; idle(4);
    busRd(regAddr(0, O_STAT), d); check("R7 rising ignored", d, 32'h0);
    @(negedge clk); padIn[5] = 1'b0; idle(4);
    busRd(regAddr(0, O_STAT), d); check("R7 falling latched", d, 32'h0000_0020);
    busWr(regAddr(0, O_STAT), 32'hFFFF_FFFF);
    busWr(regAddr(0, O_RISE), 32'h0000_0040);
    busWr(regAddr(0, O_FALL), 32'h0000_0040);
    @(negedge clk); padIn[6] = 1'b1; idle(4);
    busRd(regAddr(0, O_STAT), d); check("R7 both rise", d, 32'h0000_0040);
    busWr(regAddr(0, O_STAT), 32'h0000_0040);
    @(negedge clk); padIn[6] = 1'b0; idle(4);
    busRd(regAddr(0, O_STAT), d); check("R7 both fall", d, 32'h0000_0040);
    tidyBank(0);
  endtask

  task automatic testSticky();
    logic [31:0] d;
    busWr(regAddr(1, O_RISE), 32'h1);
    @(negedge clk); padIn[32] = 1'b1; idle(2);
    @(negedge clk); padIn[32] = 1'b0; idle(10);
    busRd(regAddr(1, O_STAT), d); check("R8 stays set", d, 32'h1);
    busWr(regAddr(1, O_STAT), 32'h0);
    busRd(regAddr(1, O_STAT), d); check("R8 zero write keeps", d, 32'h1);
    busWr(regAddr(1, O_STAT), 32'hFFFF_FFFE);
    busRd(regAddr(1, O_STAT), d); check("R8 other bits keep", d, 32'h1);
    busWr(regAddr(1, O_STAT), 32'h1);
    busRd(regAddr(1, O_STAT), d); check("R8 one clears", d, 32'h0);
  endtask

  task automatic testCollide();
    logic [31:0] d;
    @(negedge clk); padIn[32] = 1'b1; idle(4);
    @(negedge clk); padIn[32] = 1'b0; idle(4);
    busRd(regAddr(1, O_STAT), d); check("R9 armed", d, 32'h1);
    @(negedge clk); padIn[32] = 1'b1;
    @(negedge clk);
    busWr(regAddr(1, O_STAT), 32'h1);
    busRd(regAddr(1, O_STAT), d); check("R9 edge beats clear", d, 32'h1);
    busWr(regAddr(1, O_STAT), 32'h1);
    busRd(regAddr(1, O_STAT), d); check("R9 clear without edge", d, 32'h0);
    @(negedge clk); padIn[32] = 1'b0; idle(4);
  endtask

  task automatic testMask();
    logic [31:0] d;
    @(negedge clk); padIn[32] = 1'b1; idle(4);
    check("R10 irq raised", {31'b0, irq}, 32'h1);
    busWr(regAddr(1, O_MASK), 32'hFFFF_FFFE);
    check("R10 masked", {31'b0, irq}, 32'h0);
    busRd(regAddr(1, O_STAT), d); check("R10 status kept under mask", d, 32'h1);
    busWr(regAddr(1, O_MASK), 32'hFFFF_FFFF);
    check("R10 unmasked", {31'b0, irq}, 32'h1);
    busWr(regAddr(1, O_STAT), 32'h1);
    check("R10 cleared", {31'b0, irq}, 32'h0);
    @(negedge clk); padIn[32] = 1'b0; idle(4);
    tidyBank(1);
  endtask

  task automatic testLast();
    logic [31:0] d;
    busWr(regAddr(5, O_SET), 32'hFFFF_FFFF);
    busRd(regAddr(5, O_SET), d); check("R11 set trimmed", d, 32'h000F_FFFF);
    check("R11 pads", {12'h0, padOut[179:160]}, 32'h000F_FFFF);
    busWr(regAddr(5, O_CLR), 32'hFFFF_FFFF);
    busWr(regAddr(5, O_RISE), 32'hFFFF_FFFF);
    busRd(regAddr(5, O_RISE), d); check("R11 rise trimmed", d, 32'h000F_FFFF);
    busWr(regAddr(5, O_STAT), 32'hFFFF_FFFF);
    busRd(regAddr(5, O_STAT), d); check("R11 status clear", d, 32'h0);
    tidyBank(5);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    busRd(regAddr(0, O_MASK), d);
    busRd(12'h0F0, d); check("R12 hole reads zero", d, 32'h0);
    busRd(12'h0A8, d); check("R12 past low window", d, 32'h0);
    @(negedge clk); padIn[1] = 1'b1; idle(4);
    busWr(regAddr(0, O_LVL), 32'h0);
    busRd(regAddr(0, O_LVL), d); check("R12 level write ignored", d, 32'h0000_0002);
    check("R12 rdata holds", busRdata, 32'h0000_0002);
    @(negedge clk); padIn[1] = 1'b0; idle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMap();
    testSetClr();
    testDir();
    testLevel();
    testRise();
    testFallBoth();
    testSticky();
    testCollide();
    testMask();
    testLast();
    testUnmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule